// File: doc/BRIEF.md
# USB Interrupt Status Aggregator

This block holds the interrupt flags of a USB device/host controller. Event pulses from the serial interface engine set sticky flag bits. Software clears a flag by writing a one to its bit position. Each flag is gated by its own bit in a mask register. The gated flags are ORed with an external on-the-go status input to drive one processor interrupt line.

Two sources of events live inside the block.

- A bus-idle timer raises the sleep flag after the bus has been quiet for a programmable number of milliseconds. Its clock rate is a parameter.
- A token-status stage presents the status of the most recently completed token. It can queue one more completed token behind it. That queued status moves forward when software clears the token-done flag.

Software reaches both registers through a synchronous port. A one-bit select chooses between the flag register and the mask register. Read data is combinational from the registered state.

Top module: `usb_irq_status_top`

## Requirements
- R1: After reset, the flag register (select 0) and the mask register (select 1) both read 0x00, `tok_stat` is zero and `irq` is low.
- R2: Flag bits are write-one-to-clear. Writing a 1 to a bit of the flag register clears that bit, and writing a 0 leaves it as it was. The flag bit positions, from bit 7 down to bit 0, are: stall, attach, resume, sleep, token-done, start-of-frame, error, bus-reset.
- R3: A one-cycle pulse on `ev_stall`, `ev_resume`, `ev_sof`, `ev_error` or `ev_busrst` sets the matching flag on the next clock edge. The flag then stays set until it is cleared.
- R4: `ev_attach` sets the attach flag (bit 6) only while `host_mode` is 1. Otherwise it is ignored.
- R5: When `bus_active` has been low for IDLE_MS milliseconds of CLK_HZ cycles, the sleep flag (bit 4) sets. The timer does not fire again until `bus_active` has been high at least once. Any cycle with `bus_active` high restarts the timer.
- R6: When `tok_done` pulses while the token-done flag (bit 3) is clear, `tok_info` is copied to `tok_stat` and the token-done flag sets.
- R7: When `tok_done` pulses while the token-done flag is set and no token is queued, `tok_info` is queued. Clearing the token-done flag then moves the queued value into `tok_stat`, and the flag stays set. A clear with nothing queued zeroes `tok_stat` and clears the flag.
- R8: When `tok_done` pulses while a token is already queued and no clear arrives in the same cycle, `tok_ovf` is high in that cycle. The new token is discarded.
- R9: An event pulse that arrives in the same cycle as a write-one-to-clear of its own bit leaves that bit set.
- R10: `irq` is high whenever `otg_irq` is high, or any flag is set whose mask bit is set. The mask register is written and read at select 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 flags, 1 mask |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ev_stall | input | 1 | Stall handshake event pulse |
| ev_attach | input | 1 | Device attach event pulse |
| ev_resume | input | 1 | Resume signalling event pulse |
| ev_sof | input | 1 | Start-of-frame token event pulse |
| ev_error | input | 1 | Error event pulse |
| ev_busrst | input | 1 | Bus reset event pulse |
| host_mode | input | 1 | Host mode enabled |
| bus_active | input | 1 | Bus activity seen this cycle |
| tok_done | input | 1 | Token completion pulse |
| tok_info | input | TOK_W | Status of the completing token |
| otg_irq | input | 1 | External on-the-go interrupt request |
| tok_stat | output | TOK_W | Visible token status |
| tok_ovf | output | 1 | Token dropped: the queue was full |
| irq | output | 1 | Combined processor interrupt |

## Verification
The bench fires each event source on its own. This shows whether every pulse lands on its own bit position and on no other.

Writes of zero, single-bit clears and all-ones clears tell a true write-one-to-clear apart from a plain register write. A clear in the same cycle as an event separates "event wins" from "clear wins".

Three back-to-back token completions fill the visible slot, then the queue, then overflow. Two clears then show forwarding apart from emptying. The idle timer is checked on both sides of its terminal count, and again after a long quiet stretch to prove it fires only once.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
    localparam int NFLAGS   = 8;
    localparam int B_BUSRST = 0;
    localparam int B_ERROR  = 1;
    localparam int B_SOF    = 2;
    localparam int B_TOKDNE = 3;
    localparam int B_SLEEP  = 4;
    localparam int B_RESUME = 5;
    localparam int B_ATTACH = 6;
    localparam int B_STALL  = 7;

    typedef logic [NFLAGS-1:0] flags_t;

    typedef enum logic {
        SEL_FLAGS = 1'b0,
        SEL_MASK  = 1'b1
    } reg_sel_e;

    // Packed MSB-first so the struct lines up with the flag bit positions.
    typedef struct packed {
        logic stall;
        logic attach;
        logic resume;
        logic sleep;
        logic tokdne;
        logic sof;
        logic error;
        logic busrst;
    } ev_vec_t;

    function automatic logic sticky_next(logic q, logic clr, logic set);
        return (q & ~clr) | set;
    endfunction
endpackage

// File: rtl/usb_idle_timer.sv
module usb_idle_timer #(
    parameter int CLK_HZ  = 48_000_000,
    parameter int IDLE_MS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_active,
    output logic idle_pulse
);
    localparam longint TICKS_L = (longint'(CLK_HZ) * IDLE_MS) / 1000;
    localparam int     TICKS   = (TICKS_L < 2) ? 2 : int'(TICKS_L);
    localparam int     CW      = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;
    logic          armed;
    logic          at_last;

    assign at_last = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            armed      <= 1'b1;
            idle_pulse <= 1'b0;
        end else if (bus_active) begin
            cnt        <= '0;
            armed      <= 1'b1;
            idle_pulse <= 1'b0;
        end else begin
            if (!at_last) cnt <= cnt + 1'b1;
            idle_pulse <= armed & at_last;
            if (at_last) armed <= 1'b0;
        end
    end

    AST_SLEEP_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        idle_pulse |=> !idle_pulse); // R5
    AST_SLEEP_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        bus_active |=> !idle_pulse); // R5
endmodule

// File: rtl/usb_tok_queue.sv
module usb_tok_queue #(
    parameter int TOK_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tok_done,
    input  logic [TOK_W-1:0] tok_info,
    input  logic             clr_req,
    output logic             done_flag,
    output logic [TOK_W-1:0] stat,
    output logic             ovf
);
    logic [TOK_W-1:0] hold;
    logic             hold_v;
    logic             clr_eff;

    assign clr_eff = clr_req & done_flag;
    assign ovf     = tok_done & done_flag & hold_v & ~clr_eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_flag <= 1'b0;
            stat      <= '0;
            hold      <= '0;
            hold_v    <= 1'b0;
        end else if (clr_eff) begin
            if (hold_v) begin
                stat <= hold;
                if (tok_done) hold <= tok_info;
                else          hold_v <= 1'b0;
            end else if (tok_done) begin
                stat <= tok_info;
            end else begin
                stat      <= '0;
                done_flag <= 1'b0;
            end
        end else if (tok_done) begin
            if (!done_flag) begin
                stat      <= tok_info;
                done_flag <= 1'b1;
            end else if (!hold_v) begin
                hold   <= tok_info;
                hold_v <= 1'b1;
            end
        end
    end

    AST_HOLD_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        hold_v |-> done_flag); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        ovf |=> $stable(hold) && $stable(stat)); // R8
endmodule

// File: rtl/usb_irq_flags.sv
module usb_irq_flags
    import usb_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ev_vec_t set_ev,
    input  flags_t  clr,
    input  logic    tokdne,
    output flags_t  q
);
    logic [NFLAGS-1:0] set_v;
    assign set_v = set_ev;

    for (genvar i = 0; i < NFLAGS; i++) begin : g_bit
        if (i == B_TOKDNE) begin : g_ext
            assign q[i] = tokdne;
        end else begin : g_sticky
            always_ff @(posedge clk) begin
                if (rst) q[i] <= 1'b0;
                else     q[i] <= sticky_next(q[i], clr[i], set_v[i]);
            end

            AST_W1C_ONLY: assert property (@(posedge clk) disable iff (rst)
                (q[i] && !clr[i]) |=> q[i]); // R2
            AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
                (set_v[i] && clr[i]) |=> q[i]); // R9
        end
    end
endmodule

// File: rtl/usb_irq_status_top.sv
module usb_irq_status_top
    import usb_irq_pkg::*;
#(
    parameter int CLK_HZ  = 48_000_000,
    parameter int IDLE_MS = 3,
    parameter int TOK_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             ev_stall,
    input  logic             ev_attach,
    input  logic             ev_resume,
    input  logic             ev_sof,
    input  logic             ev_error,
    input  logic             ev_busrst,
    input  logic             host_mode,
    input  logic             bus_active,
    input  logic             tok_done,
    input  logic [TOK_W-1:0] tok_info,
    input  logic             otg_irq,
    output logic [TOK_W-1:0] tok_stat,
    output logic             tok_ovf,
    output logic             irq
);
    flags_t  flags;
    flags_t  mask;
    flags_t  clr;
    ev_vec_t ev;
    logic    idle_pulse;
    logic    tokdne;
    logic    wr_flags;
    logic    wr_mask;

    assign wr_flags = reg_wr & (reg_sel_e'(reg_sel) == SEL_FLAGS);
    assign wr_mask  = reg_wr & (reg_sel_e'(reg_sel) == SEL_MASK);
    assign clr      = wr_flags ? reg_wdata : '0;

    always_comb begin
        ev        = '0;
        ev.stall  = ev_stall;
        ev.attach = ev_attach & host_mode;
        ev.resume = ev_resume;
        ev.sleep  = idle_pulse;
        ev.sof    = ev_sof;
        ev.error  = ev_error;
        ev.busrst = ev_busrst;
    end

    always_ff @(posedge clk) begin
        if (rst)          mask <= '0;
        else if (wr_mask) mask <= reg_wdata;
    end

    usb_idle_timer #(.CLK_HZ(CLK_HZ), .IDLE_MS(IDLE_MS)) u_idle (
        .clk(clk), .rst(rst), .bus_active(bus_active), .idle_pulse(idle_pulse)
    );

    usb_tok_queue #(.TOK_W(TOK_W)) u_tok (
        .clk(clk), .rst(rst), .tok_done(tok_done), .tok_info(tok_info),
        .clr_req(clr[B_TOKDNE]), .done_flag(tokdne), .stat(tok_stat), .ovf(tok_ovf)
    );

    usb_irq_flags u_flags (
        .clk(clk), .rst(rst), .set_ev(ev), .clr(clr), .tokdne(tokdne), .q(flags)
    );

    assign irq       = otg_irq | (|(flags & mask));
    assign reg_rdata = (reg_sel_e'(reg_sel) == SEL_MASK) ? mask : flags;

    AST_ATTACH_HOST: assert property (@(posedge clk) disable iff (rst)
        (!host_mode && !flags[B_ATTACH]) |=> !flags[B_ATTACH]); // R4
    AST_OTG_PASS: assert property (@(posedge clk) disable iff (rst)
        otg_irq |-> irq); // R10
endmodule

// File: tb/sim_usb_irq_status_top.sv
module sim_usb_irq_status_top;
    localparam int CLK_HZ = 10_000;
    localparam int TICKS  = CLK_HZ * 3 / 1000;

    logic       clk = 0;
    logic       rst = 1;
    logic       reg_wr = 0, reg_sel = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic       ev_stall = 0, ev_attach = 0, ev_resume = 0, ev_sof = 0;
    logic       ev_error = 0, ev_busrst = 0, host_mode = 0, bus_active = 1;
    logic       tok_done = 0, otg_irq = 0, tok_ovf, irq;
    logic [7:0] tok_info = 0, tok_stat;
    int         errors = 0, checks = 0;

    always #5 clk = ~clk;

    usb_irq_status_top #(.CLK_HZ(CLK_HZ), .IDLE_MS(3), .TOK_W(8)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_stall(ev_stall), .ev_attach(ev_attach), .ev_resume(ev_resume),
        .ev_sof(ev_sof), .ev_error(ev_error), .ev_busrst(ev_busrst),
        .host_mode(host_mode), .bus_active(bus_active), .tok_done(tok_done),
        .tok_info(tok_info), .otg_irq(otg_irq), .tok_stat(tok_stat),
        .tok_ovf(tok_ovf), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    task automatic wr(logic sel, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_sel = 0; reg_wdata = 0;
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1;
        @(negedge clk); s = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(0, v); check("R1 flags", v, 8'h00);
        rd(1, v); check("R1 mask", v, 8'h00);
        reg_sel = 0;
        check("R1 tok_stat", tok_stat, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_events();
        logic [7:0] v;
        pulse(ev_stall);  rd(0, v); check("R3 stall", v, 8'h80); wr(0, 8'hFF);
        pulse(ev_resume); rd(0, v); check("R3 resume", v, 8'h20); wr(0, 8'hFF);
        pulse(ev_sof);    rd(0, v); check("R3 sof", v, 8'h04); wr(0, 8'hFF);
        pulse(ev_error);  rd(0, v); check("R3 error", v, 8'h02); wr(0, 8'hFF);
        pulse(ev_busrst); rd(0, v); check("R3 busrst", v, 8'h01);
        pulse(ev_sof);
        pulse(ev_stall);
        wr(0, 8'h00);     rd(0, v); check("R2 zero write", v, 8'h85);
        wr(0, 8'h04);     rd(0, v); check("R2 single clear", v, 8'h81);
        wr(0, 8'hFF);     rd(0, v); check("R2 clear all", v, 8'h00);
    endtask

    task automatic t_attach();
        logic [7:0] v;
        host_mode = 0;
        pulse(ev_attach); rd(0, v); check("R4 attach device mode", v, 8'h00);
        host_mode = 1;
        pulse(ev_attach); rd(0, v); check("R4 attach host mode", v, 8'h40);
        wr(0, 8'h40); host_mode = 0;
    endtask

    task automatic t_set_wins();
        logic [7:0] v;
        @(negedge clk);
        ev_error = 1; reg_wr = 1; reg_sel = 0; reg_wdata = 8'h02;
        @(negedge clk);
        ev_error = 0; reg_wr = 0; reg_wdata = 0;
        rd(0, v); check("R9 event beats clear", v, 8'h02);
        wr(0, 8'h02);
        rd(0, v); check("R9 later clear", v, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        otg_irq = 1; #1 check("R10 otg passthrough", irq, 1);
        otg_irq = 0;
        pulse(ev_stall); #1 check("R10 masked off", irq, 0);
        wr(1, 8'h80); rd(1, v); check("R10 mask readback", v, 8'h80);
        reg_sel = 0; #1 check("R10 enabled source", irq, 1);
        wr(1, 8'h7F); #1 check("R10 other bits enabled", irq, 0);
        wr(0, 8'h80); wr(1, 8'h00);
    endtask

    task automatic t_tokens();
        logic [7:0] v;
        @(negedge clk); tok_done = 1; tok_info = 8'hA1;
        @(negedge clk); tok_info = 8'hB2;
        rd(0, v); check("R6 done flag", v, 8'h08);
        check("R6 tok_stat first", tok_stat, 8'hA1);
        @(negedge clk); tok_info = 8'hC3;
        #1 check("R8 overflow high", tok_ovf, 1);
        @(negedge clk); tok_done = 0; tok_info = 0;
        #1 check("R8 ovf low idle", tok_ovf, 0);
        wr(0, 8'h08);
        rd(0, v); check("R7 flag kept", v, 8'h08);
        check("R7 queued forwarded", tok_stat, 8'hB2);
        wr(0, 8'h08);
        rd(0, v); check("R7 flag cleared", v, 8'h00);
        check("R7 tok_stat zero", tok_stat, 8'h00);
    endtask

    task automatic t_sleep();
        logic [7:0] v;
        @(negedge clk); bus_active = 0;
        repeat (TICKS - 5) @(negedge clk);
        rd(0, v); check("R5 not yet asleep", v, 8'h00);
        repeat (10) @(negedge clk);
        rd(0, v); check("R5 sleep set", v, 8'h10);
        wr(0, 8'h10);
        repeat (2 * TICKS) @(negedge clk);
        rd(0, v); check("R5 no refire", v, 8'h00);
        bus_active = 1; @(negedge clk); bus_active = 0;
        repeat (TICKS + 5) @(negedge clk);
        rd(0, v); check("R5 rearmed", v, 8'h10);
        bus_active = 1; wr(0, 8'h10);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_events();
        t_attach();
        t_set_wins();
        t_irq();
        t_tokens();
        t_sleep();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule